// File: doc/BRIEF.md
# Memory Map Decoder and DRAM Strobe Sequencer

This block sits between an 8-bit CPU's memory bus and its memory devices. It splits the 64 KiB space three ways. The bottom 16 KiB goes to a ROM whose chip select is a combinational decode. The next 16 KiB is a base DRAM bank built as a 128 x 128 array. The top 32 KiB is an expansion DRAM bank that has 128 rows and 256 columns. An external ROM-disable input lets an add-on ROM take over the low range.

For each DRAM access the block runs a short strobe sequence on the master clock. The row part of the address goes out on a shared 8-bit DRAM address bus while RAS is high. RAS then falls to latch the row. One cycle later the multiplexer switches to the column bits, and CAS falls one cycle after that. Both strobes return high on the first clock edge at which the memory request is seen released. The expansion bank is built from 64k devices of which only one half works. Its extra row bit is tied to a configuration input, which picks the working half.

The DRAM write enable is decoded from the CPU read and write strobes.

Top module: `mem_map_dram_ctl`

## Requirements
- R1: `rom_cs_n` is low, combinationally, exactly when `mreq_n` and `rd_n` are both low, `cpu_addr[15:14]` is 00 and `rom_off` is low. In every other case it is high.
- R2: While `rom_off` is high, `rom_cs_n` stays high for any address and strobe pattern.
- R3: A request to 4000-7FFF (`cpu_addr[15:14]` = 01) with `mreq_n` low at rising edge E0 drives `base_ras_n` low from edge E1 onward. Both strobes are still high after E0. An access to the ROM range starts no DRAM strobe.
- R4: A request to 8000-FFFF (`cpu_addr[15]` = 1) runs the same sequence on `exp_ras_n`/`exp_cas_n`. The strobes of the other bank stay high, and the two RAS outputs are never low together.
- R5: From E0 until edge E2, `dram_addr[6:0]` carries `cpu_addr[6:0]`, which is the row address.
- R6: From edge E2 onward the column is driven. For the base bank this is `{1'b0, cpu_addr[13:7]}`. For the expansion bank it is `cpu_addr[14:7]`.
- R7: CAS of the active bank falls at edge E3, one cycle after the column switch, while RAS is still low.
- R8: At the first rising edge that samples `mreq_n` high, both RAS and CAS of both banks go high. This includes an access released before CAS has fallen, in which case CAS never falls.
- R9: `dram_we_n` is low exactly when `wr_n` is low and `rd_n` is high. Otherwise it is high.
- R10: While `rst_n` is low at a rising edge, all four strobes are high after that edge, even with a request pending.
- R11: In the row phase, `dram_addr[7]` equals `exp_half` for the expansion bank and is 0 for the base bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_addr | input | 16 | CPU address bus |
| mreq_n | input | 1 | Memory request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| rom_off | input | 1 | External ROM disable, active high |
| exp_half | input | 1 | Working-half select, used as the expansion bank's extra row bit |
| rom_cs_n | output | 1 | ROM chip select, active low |
| dram_addr | output | 8 | Multiplexed row/column DRAM address |
| base_ras_n | output | 1 | Base bank row strobe |
| base_cas_n | output | 1 | Base bank column strobe |
| exp_ras_n | output | 1 | Expansion bank row strobe |
| exp_cas_n | output | 1 | Expansion bank column strobe |
| dram_we_n | output | 1 | DRAM write enable, active low |

## Verification
The ROM select and write enable are combinational, so the bench checks them 1 ns after the inputs change, with no clock edge in between. The strobe sequence is counted from E0, the first rising edge that sees the request: both RAS outputs are still high after E0, RAS is low after E1, the column is on the bus after E2, and CAS is low after E3. Release takes effect at the first edge after `mreq_n` rises. The bench drives inputs on the falling edge and samples on the next falling edge after each counted rising edge, so every comparison lands exactly on the cycle the requirement names, with no slack.

// File: rtl/mdram_pkg.sv
// Package mdram_pkg
// Shared types for the memory map decoder and DRAM strobe sequencer.
// Assumes a single master clock domain.
package mdram_pkg;

    // Strobe sequencer phases, in the order they are visited.
    typedef enum logic [2:0] {
        SQ_IDLE  = 3'd0,   // no access, strobes high
        SQ_ROW   = 3'd1,   // row on the bus, RAS high
        SQ_RASLO = 3'd2,   // RAS low, row still held
        SQ_COL   = 3'd3,   // column on the bus, CAS high
        SQ_CASLO = 3'd4    // CAS low until release
    } seq_state_t;

endpackage

// File: rtl/mdram_region_dec.sv
// Module mdram_region_dec
// Purely combinational decode of the CPU bus into the ROM select, the two
// DRAM bank hits and the DRAM write enable.
// Assumes: ROM in the lowest quarter, base bank in the second quarter,
// expansion bank in the upper half of the address space.
module mdram_region_dec #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              mreq_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              rom_off,
    output logic              rom_cs_n,
    output logic              base_hit,
    output logic              exp_hit,
    output logic              we_n
);
    localparam int TOP = ADDR_W - 1;
    localparam int NXT = ADDR_W - 2;

    logic in_rom_range;

    // Classify the address into one of the three regions.
    always_comb begin
        in_rom_range = !cpu_addr[TOP] && !cpu_addr[NXT];
        base_hit     = !cpu_addr[TOP] &&  cpu_addr[NXT];
        exp_hit      =  cpu_addr[TOP];
    end

    // ROM select: memory read in the ROM range, unless overridden externally.
    always_comb begin
        rom_cs_n = !(in_rom_range && !mreq_n && !rd_n && !rom_off);
    end

    // Write enable: only a clean write strobe with read inactive.
    always_comb begin
        we_n = !(!wr_n && rd_n);
    end

endmodule

// File: rtl/mdram_strobe_seq.sv
// Module mdram_strobe_seq
// RAS/CAS sequencer for one DRAM bank. It starts when a memory request hits
// the bank, walks row -> RAS low -> column -> CAS low, and returns to idle
// on the first edge that sees the request released.
// Assumes the CPU keeps the address stable while mreq_n is low.
module mdram_strobe_seq
    import mdram_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mreq_n,
    input  logic hit,
    output logic ras_n,
    output logic cas_n,
    output logic col_phase,
    output logic busy
);
    seq_state_t st;

    // Phase register: advance one phase per clock, drop to idle on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= SQ_IDLE;
        end else if (mreq_n) begin
            st <= SQ_IDLE;
        end else begin
            case (st)
                SQ_IDLE:  st <= hit ? SQ_ROW : SQ_IDLE;
                SQ_ROW:   st <= SQ_RASLO;
                SQ_RASLO: st <= SQ_COL;
                SQ_COL:   st <= SQ_CASLO;
                SQ_CASLO: st <= SQ_CASLO;
                default:  st <= SQ_IDLE;
            endcase
        end
    end

    // Strobe and mux-phase decode of the phase register.
    always_comb begin
        ras_n     = !(st == SQ_RASLO || st == SQ_COL || st == SQ_CASLO);
        cas_n     = !(st == SQ_CASLO);
        col_phase =  (st == SQ_COL || st == SQ_CASLO);
        busy      =  (st != SQ_IDLE);
    end

    // R8: a released request leaves both strobes high after the next edge.
    a_r8_release_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_n |=> (ras_n && cas_n));

    // R7: CAS only falls after a cycle of column phase with RAS already low.
    a_r7_cas_after_col: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> ($past(col_phase) && $past(!ras_n) && !ras_n));

    // R7: CAS is never low while RAS is high.
    a_r7_cas_needs_ras: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);

endmodule

// File: rtl/mdram_addr_mux.sv
// Module mdram_addr_mux
// Builds the shared DRAM address: the row (low address bits plus a half
// select bit) or the column (high address bits) of whichever bank is active.
// Assumes the column of the expansion bank is one bit wider than the base.
module mdram_addr_mux #(
    parameter int ADDR_W = 16,
    parameter int ROW_W  = 7
) (
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              exp_half,
    input  logic              exp_sel,
    input  logic              col_phase,
    output logic [ROW_W:0]    dram_addr
);
    localparam int DA_W  = ROW_W + 1;
    localparam int BCOL_W = ADDR_W - 2 - ROW_W;
    localparam int ECOL_W = ADDR_W - 1 - ROW_W;

    logic [DA_W-1:0]   row_word;
    logic [BCOL_W-1:0] base_col;
    logic [ECOL_W-1:0] exp_col;

    // Row word: low address bits; top bit is the half select for expansion.
    always_comb begin
        row_word = {exp_sel ? exp_half : 1'b0, cpu_addr[ROW_W-1:0]};
    end

    // Column fields of each bank.
    always_comb begin
        base_col = cpu_addr[ADDR_W-3:ROW_W];
        exp_col  = cpu_addr[ADDR_W-2:ROW_W];
    end

    // Output select by phase and bank.
    always_comb begin
        if (!col_phase)    dram_addr = row_word;
        else if (exp_sel)  dram_addr = DA_W'(exp_col);
        else               dram_addr = DA_W'(base_col);
    end

endmodule

// File: rtl/mem_map_dram_ctl.sv
// Module mem_map_dram_ctl
// Top: decodes the CPU memory request into ROM select and two DRAM banks,
// and runs one RAS/CAS sequencer per bank sharing one address multiplexer.
// Assumes one master clock, synchronous active-low reset, and that the two
// banks are never requested at once (the address picks exactly one).
module mem_map_dram_ctl #(
    parameter int ADDR_W = 16,
    parameter int ROW_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              mreq_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              rom_off,
    input  logic              exp_half,
    output logic              rom_cs_n,
    output logic [ROW_W:0]    dram_addr,
    output logic              base_ras_n,
    output logic              base_cas_n,
    output logic              exp_ras_n,
    output logic              exp_cas_n,
    output logic              dram_we_n
);
    localparam int NBANK = 2;
    localparam int BK_BASE = 0;
    localparam int BK_EXP  = 1;

    logic             base_hit, exp_hit;
    logic [NBANK-1:0] hit_v, ras_v, cas_v, col_v, busy_v;

    mdram_region_dec #(.ADDR_W(ADDR_W)) i_dec (
        .cpu_addr (cpu_addr),
        .mreq_n   (mreq_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .rom_off  (rom_off),
        .rom_cs_n (rom_cs_n),
        .base_hit (base_hit),
        .exp_hit  (exp_hit),
        .we_n     (dram_we_n)
    );

    // Gather bank hits into a vector indexed by bank number.
    always_comb begin
        hit_v[BK_BASE] = base_hit;
        hit_v[BK_EXP]  = exp_hit;
    end

    // One sequencer per bank.
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        mdram_strobe_seq i_seq (
            .clk       (clk),
            .rst_n     (rst_n),
            .mreq_n    (mreq_n),
            .hit       (hit_v[b]),
            .ras_n     (ras_v[b]),
            .cas_n     (cas_v[b]),
            .col_phase (col_v[b]),
            .busy      (busy_v[b])
        );
    end

    // Shared multiplexer follows the active bank; expansion when it is busy.
    mdram_addr_mux #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) i_mux (
        .cpu_addr  (cpu_addr),
        .exp_half  (exp_half),
        .exp_sel   (busy_v[BK_EXP] || (!busy_v[BK_BASE] && exp_hit)),
        .col_phase (|col_v),
        .dram_addr (dram_addr)
    );

    // Strobe outputs per bank.
    always_comb begin
        base_ras_n = ras_v[BK_BASE];
        base_cas_n = cas_v[BK_BASE];
        exp_ras_n  = ras_v[BK_EXP];
        exp_cas_n  = cas_v[BK_EXP];
    end

    // R4: the two banks never hold RAS low together.
    a_r4_one_bank_active: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!base_ras_n, !exp_ras_n}));

    // R3: a ROM-range address never has a DRAM row strobe starting.
    a_r3_rom_no_ras: assert property (@(posedge clk) disable iff (!rst_n)
        (base_ras_n && exp_ras_n && cpu_addr[ADDR_W-1:ADDR_W-2] == 2'b00)
        |=> (base_ras_n && exp_ras_n));

    // R1: the ROM select is only ever active in the ROM range.
    a_r1_rom_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_cs_n |-> (cpu_addr[ADDR_W-1:ADDR_W-2] == 2'b00 && !mreq_n));

    // R2: the external disable keeps the ROM deselected.
    a_r2_rom_off_wins: assert property (@(posedge clk) disable iff (!rst_n)
        rom_off |-> rom_cs_n);

    // R9: write enable never active together with a read strobe.
    a_r9_we_not_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_we_n |-> (rd_n && !wr_n));

endmodule

// File: tb/test_mem_map_dram_ctl.sv
module test_mem_map_dram_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic        mreq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic        rom_off = 1'b0, exp_half = 1'b0;
    logic        rom_cs_n, base_ras_n, base_cas_n, exp_ras_n, exp_cas_n, dram_we_n;
    logic [7:0]  dram_addr;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;   // 250 MHz

    mem_map_dram_ctl i_mem_map_dram_ctl (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .mreq_n(mreq_n),
        .rd_n(rd_n), .wr_n(wr_n), .rom_off(rom_off), .exp_half(exp_half),
        .rom_cs_n(rom_cs_n), .dram_addr(dram_addr),
        .base_ras_n(base_ras_n), .base_cas_n(base_cas_n),
        .exp_ras_n(exp_ras_n), .exp_cas_n(exp_cas_n), .dram_we_n(dram_we_n)
    );

    // Vector: [21:6] addr, [5] write, [4] rom_off, [3] exp_half,
    //         [2:1] bank (0 none, 1 base, 2 expansion), [0] ROM selected
    localparam int NV = 11;
    localparam logic [21:0] VEC [0:NV-1] = '{
        {16'h0123, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1},
        {16'h3FFF, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0},
        {16'h4000, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0},
        {16'h7FFF, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0},
        {16'h5A5A, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0},
        {16'h8000, 1'b0, 1'b0, 1'b0, 2'd2, 1'b0},
        {16'hFFFF, 1'b1, 1'b0, 1'b1, 2'd2, 1'b0},
        {16'hC3A5, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0},
        {16'h9234, 1'b1, 1'b0, 1'b0, 2'd2, 1'b0},
        {16'h2AAA, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0},
        {16'h6B3C, 1'b1, 1'b1, 1'b0, 2'd1, 1'b0}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic strobes(input string req, input logic [3:0] exp);
        chk(req, "ras/cas {base_ras,base_cas,exp_ras,exp_cas}",
            {28'd0, base_ras_n, base_cas_n, exp_ras_n, exp_cas_n}, {28'd0, exp});
    endtask

    // Expected strobe pattern for a bank with given RAS/CAS levels.
    function automatic logic [3:0] pat(input int bank, input logic ras, input logic cas);
        if (bank == 1) return {ras, cas, 2'b11};
        if (bank == 2) return {2'b11, ras, cas};
        return 4'b1111;
    endfunction

    task automatic release_bus;
        mreq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic run_vec(input logic [21:0] v);
        logic [15:0] a;
        logic [7:0]  row, col;
        int          bank;
        a = v[21:6];
        bank = int'(v[2:1]);
        row = {(bank == 2) ? v[3] : 1'b0, a[6:0]};
        col = (bank == 2) ? a[14:7] : {1'b0, a[13:7]};
        cpu_addr = a; rom_off = v[4]; exp_half = v[3];
        rd_n = v[5]; wr_n = !v[5]; mreq_n = 1'b0;
        #1;
        chk(v[4] ? "R2" : "R1", "rom_cs_n", {31'd0, rom_cs_n}, {31'd0, !v[0]});
        chk("R9", "dram_we_n", {31'd0, dram_we_n}, {31'd0, !v[5]});
        tick;  // after E0
        strobes("R3", 4'b1111);
        if (bank != 0) chk("R5", "row after E0", {24'd0, dram_addr}, {24'd0, row});
        tick;  // after E1
        strobes(bank == 2 ? "R4" : "R3", pat(bank, 1'b0, 1'b1));
        if (bank != 0) chk("R11", "row while RAS low", {24'd0, dram_addr}, {24'd0, row});
        tick;  // after E2
        strobes("R6", pat(bank, 1'b0, 1'b1));
        if (bank != 0) chk("R6", "column", {24'd0, dram_addr}, {24'd0, col});
        tick;  // after E3
        strobes("R7", pat(bank, 1'b0, 1'b0));
        if (bank != 0) chk("R6", "column held", {24'd0, dram_addr}, {24'd0, col});
        release_bus;
        #1;
        chk("R9", "we released", {31'd0, dram_we_n}, 32'd1);
        tick;
        strobes("R8", 4'b1111);
        tick;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R10: request pending during reset leaves strobes high.
        @(negedge clk);
        cpu_addr = 16'h4567; mreq_n = 1'b0; rd_n = 1'b0;
        repeat (4) tick;
        strobes("R10", 4'b1111);
        cpu_addr = 16'h9876;
        tick;
        strobes("R10", 4'b1111);
        release_bus;
        tick;
        rst_n = 1'b1;
        tick;

        // Table walk
        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R8: release before CAS falls, CAS must never go low.
        cpu_addr = 16'h4ABC; rd_n = 1'b0; mreq_n = 1'b0;
        tick; tick;
        strobes("R8", 4'b0111);
        release_bus;
        tick;
        strobes("R8", 4'b1111);
        tick;
        strobes("R8", 4'b1111);

        // R8: expansion released right after E0.
        cpu_addr = 16'hA001; rd_n = 1'b0; mreq_n = 1'b0;
        tick;
        release_bus;
        tick;
        strobes("R8", 4'b1111);

        // R9: both strobes low -> no write enable.
        rd_n = 1'b0; wr_n = 1'b0; #1;
        chk("R9", "we with rd and wr low", {31'd0, dram_we_n}, 32'd1);
        // R1: read strobe missing -> no ROM select.
        cpu_addr = 16'h0010; mreq_n = 1'b0; rd_n = 1'b1; wr_n = 1'b1; #1;
        chk("R1", "rom_cs_n without rd", {31'd0, rom_cs_n}, 32'd1);
        // R1: mreq missing -> no ROM select.
        mreq_n = 1'b1; rd_n = 1'b0; #1;
        chk("R1", "rom_cs_n without mreq", {31'd0, rom_cs_n}, 32'd1);
        release_bus;
        tick;

        // R10: reset in the middle of an access returns strobes high.
        cpu_addr = 16'hF0F0; rd_n = 1'b0; mreq_n = 1'b0;
        tick; tick; tick; tick;
        strobes("R7", 4'b1100);
        rst_n = 1'b0;
        tick;
        strobes("R10", 4'b1111);
        release_bus;
        rst_n = 1'b1;
        tick;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule